// File: doc/BRIEF.md
# Fault Status Latch with Timed Clear

This block produces one active-high fault line for a host controller that drives an eight-bit serial command link. The line is the OR of several sources: per-channel short-circuit flags, which pass straight through, a sticky overtemperature indication, two sticky frame-length errors, a power-up marker, and a standby indication. The standby indication is high whenever every command bit is zero, so the host can check the status line itself.

The block watches single-cycle event pulses from the serial front end. These are chip select falling (frame open), chip select rising (frame close), and the falling and rising edges of the serial clock. From them it counts clock positions inside each frame. Each sticky error is released at its own falling-clock position in a later frame: a short frame at position 8, an overlong frame at position 2, and overtemperature at position 4. Position 4 only releases overtemperature if the sensor has gone quiet by then. The host can therefore tell which fault it saw from the moment the line drops.

The frame tracker is a three-state machine. Its states are FR_IDLE (chip select high), FR_COUNT (frame open, at most eight rising clocks seen) and FR_OVER (a ninth rising clock was seen). Its transitions are:
- open: FR_IDLE to FR_COUNT on frame_start.
- overflow: FR_COUNT to FR_OVER on the ninth rising clock.
- close: FR_COUNT or FR_OVER back to FR_IDLE on frame_end.

Top module: `fault_status_latch`

## Requirements
- R1: While any bit of short_flags is 1, fault_status is 1. The short indication is not stored, so it stops contributing once the flags return to 0.
- R2: While cmd_idle is 1, fault_status is 1.
- R3: After reset, fault_status is 1. The power-up marker is cleared by the first frame_start pulse.
- R4: When a frame closes with fewer than 8 falling serial clocks counted, a short-frame error is latched. It is visible in the cycle after the frame_end pulse.
- R5: A latched short-frame error is released by the 8th falling serial clock of a later frame.
- R6: The 9th rising serial clock inside one frame latches an overlong-frame error. It is visible in the cycle after that pulse.
- R7: A latched overlong-frame error is released by the 2nd falling serial clock of a later frame.
- R8: A high overtemp input latches an overtemperature indication. The 4th falling serial clock of a frame releases it only if overtemp is 0 in that cycle; if overtemp is 1, the set wins.
- R9: Serial clock pulses while no frame is open are ignored. They do not count toward any clock position and release nothing.
- R10: A frame with exactly 8 falling and at most 8 rising serial clocks latches no error.
- R11: fault_status equals the OR of the live short flags, cmd_idle, the power-up marker and the three sticky indications at every sample point. It is 0 when all of these are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| frame_start | input | 1 | One-cycle pulse: chip select fell, frame opens |
| frame_end | input | 1 | One-cycle pulse: chip select rose, frame closes |
| sclk_fall | input | 1 | One-cycle pulse: serial clock falling edge |
| sclk_rise | input | 1 | One-cycle pulse: serial clock rising edge |
| short_flags | input | NCH | Live short-circuit flag per channel |
| overtemp | input | 1 | Live overtemperature flag |
| cmd_idle | input | 1 | High when all command bits are zero |
| fault_status | output | 1 | Active-high fault / diagnostic line |

## Verification
The bench targets the boundary clock positions. A frame of exactly eight clocks must leave no error, while seven clocks or a ninth rising clock must. A design off by one in its counter would flag good frames or miss bad ones. Each release is checked one position early and at the exact position, so swapped or shifted clear indices show up as a line that drops at the wrong time. Overtemperature is held high across the 4th clock to catch a clear that beats the set. Clocks sent with chip select high are checked for having no effect, to expose a counter that keeps running between frames.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_COUNT = 2'd1,
        FR_OVER  = 2'd2
    } frame_state_e;
endpackage

// File: rtl/fsl_sticky.sv
module fsl_sticky #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= RST_VAL;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R5
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/fsl_frame_fsm.sv
module fsl_frame_fsm
    import fsl_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int CW         = $clog2(FRAME_BITS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          sclk_fall,
    input  logic          sclk_rise,
    output logic          in_frame,
    output logic          fall_evt,
    output logic [CW:0]   fall_idx,
    output logic          short_set,
    output logic          long_set
);
    localparam logic [CW-1:0] BITS_C = CW'(FRAME_BITS);
    localparam logic [CW-1:0] SAT_C  = {CW{1'b1}};

    frame_state_e   state_q, state_d;
    logic [CW-1:0]  fall_cnt_q;
    logic [CW-1:0]  rise_cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:  if (frame_start) state_d = FR_COUNT;
            FR_COUNT: begin
                if (frame_end)                                state_d = FR_IDLE;
                else if (sclk_rise && rise_cnt_q == BITS_C)   state_d = FR_OVER;
            end
            FR_OVER:  if (frame_end) state_d = FR_IDLE;
            default:  state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= FR_IDLE;
            fall_cnt_q <= '0;
            rise_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FR_IDLE) begin
                if (frame_start) begin
                    fall_cnt_q <= '0;
                    rise_cnt_q <= '0;
                end
            end else if (!frame_end) begin
                if (sclk_fall && fall_cnt_q != SAT_C)
                    fall_cnt_q <= fall_cnt_q + 1'b1;
                if (state_q == FR_COUNT && sclk_rise && rise_cnt_q != BITS_C)
                    rise_cnt_q <= rise_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        in_frame  = (state_q != FR_IDLE);
        fall_idx  = {1'b0, fall_cnt_q} + (CW+1)'(1);
        fall_evt  = in_frame && sclk_fall && !frame_end;
        short_set = in_frame && frame_end && (fall_cnt_q < BITS_C);
        long_set  = (state_q == FR_COUNT) && !frame_end && sclk_rise
                    && (rise_cnt_q == BITS_C);
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_IDLE && !frame_start) |=> $stable(fall_cnt_q));
    // R6
    over_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_set |=> (state_q == FR_OVER));
    // R4
    frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && in_frame) |=> (state_q == FR_IDLE));
endmodule

// File: rtl/fault_status_latch.sv
module fault_status_latch #(
    parameter int NCH           = 8,
    parameter int FRAME_BITS    = 8,
    parameter int CLR_SHORT_IDX = FRAME_BITS,
    parameter int CLR_LONG_IDX  = 2,
    parameter int CLR_OT_IDX    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           frame_end,
    input  logic           sclk_fall,
    input  logic           sclk_rise,
    input  logic [NCH-1:0] short_flags,
    input  logic           overtemp,
    input  logic           cmd_idle,
    output logic           fault_status
);
    localparam int CW = $clog2(FRAME_BITS + 2);
    localparam logic [CW:0] SHORT_AT = (CW+1)'(CLR_SHORT_IDX);
    localparam logic [CW:0] LONG_AT  = (CW+1)'(CLR_LONG_IDX);
    localparam logic [CW:0] OT_AT    = (CW+1)'(CLR_OT_IDX);

    logic          in_frame, fall_evt, short_set, long_set;
    logic [CW:0]   fall_idx;
    logic          por_q, sfe_q, lfe_q, ot_q;

    fsl_frame_fsm #(.FRAME_BITS(FRAME_BITS), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_end(frame_end),
        .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
        .in_frame(in_frame), .fall_evt(fall_evt), .fall_idx(fall_idx),
        .short_set(short_set), .long_set(long_set)
    );

    fsl_sticky #(.RST_VAL(1'b1)) u_por (
        .clk(clk), .rst_n(rst_n), .set_i(1'b0),
        .clr_i(frame_start && !in_frame), .q_o(por_q));

    fsl_sticky #(.RST_VAL(1'b0)) u_sfe (
        .clk(clk), .rst_n(rst_n), .set_i(short_set),
        .clr_i(fall_evt && fall_idx == SHORT_AT), .q_o(sfe_q));

    fsl_sticky #(.RST_VAL(1'b0)) u_lfe (
        .clk(clk), .rst_n(rst_n), .set_i(long_set),
        .clr_i(fall_evt && fall_idx == LONG_AT), .q_o(lfe_q));

    fsl_sticky #(.RST_VAL(1'b0)) u_ot (
        .clk(clk), .rst_n(rst_n), .set_i(overtemp),
        .clr_i(fall_evt && fall_idx == OT_AT && !overtemp), .q_o(ot_q));

    always_comb begin
        fault_status = (|short_flags) | cmd_idle | por_q | sfe_q | lfe_q | ot_q;
    end

    // R3
    por_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !in_frame) |=> !por_q);
    // R1
    short_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|short_flags) |-> fault_status);
endmodule

// File: tb/sim_fault_status_latch.sv
`timescale 1ns/1ps
module sim_fault_status_latch;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 0, frame_end = 0, sclk_fall = 0, sclk_rise = 0;
    logic [NCH-1:0] short_flags = '0;
    logic overtemp = 0, cmd_idle = 0;
    logic fault_status;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    bit m_por, m_sfe, m_lfe, m_ot, m_in, m_over;
    int m_fall, m_rise;

    always #2.5 clk = ~clk;

    fault_status_latch #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_end(frame_end),
        .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
        .short_flags(short_flags), .overtemp(overtemp),
        .cmd_idle(cmd_idle), .fault_status(fault_status));

    function automatic bit expect_status();
        return (|short_flags) | cmd_idle | m_por | m_sfe | m_lfe | m_ot;
    endfunction

    task automatic check(input string tag);
        bit e;
        e = expect_status();
        total++;
        if (fault_status !== e) begin
            bad++;
            $display("FAIL %s: fault_status=%b expected=%b at %0t", tag, fault_status, e, $time);
        end
    endtask

    task automatic model(input bit fs, input bit fe, input bit cf, input bit cr);
        int idx;
        if (fs) begin
            if (!m_in) begin
                m_por = 0; m_in = 1; m_over = 0; m_fall = 0; m_rise = 0;
            end
        end else if (fe) begin
            if (m_in && m_fall < 8) m_sfe = 1;
            m_in = 0;
        end else if (m_in && cf) begin
            idx = m_fall + 1;
            if (idx == 8) m_sfe = 0;
            if (idx == 2) m_lfe = 0;
            if (idx == 4 && !overtemp) m_ot = 0;
            if (m_fall < 15) m_fall++;
        end else if (m_in && cr && !m_over) begin
            if (m_rise == 8) begin m_lfe = 1; m_over = 1; end
            else m_rise++;
        end
        if (overtemp) m_ot = 1;
    endtask

    task automatic ev(input bit fs, input bit fe, input bit cf, input bit cr, input string tag);
        @(negedge clk);
        frame_start = fs; frame_end = fe; sclk_fall = cf; sclk_rise = cr;
        @(posedge clk);
        #1;
        frame_start = 0; frame_end = 0; sclk_fall = 0; sclk_rise = 0;
        model(fs, fe, cf, cr);
        check(tag);
    endtask

    task automatic env(input logic [NCH-1:0] sh, input bit ot, input bit idle, input string tag);
        @(negedge clk);
        short_flags = sh; overtemp = ot; cmd_idle = idle;
        @(posedge clk);
        #1;
        model(0, 0, 0, 0);
        check(tag);
    endtask

    task automatic frame(input int n, input string tag);
        ev(1, 0, 0, 0, tag);
        for (int i = 0; i < n; i++) begin
            ev(0, 0, 1, 0, tag);
            ev(0, 0, 0, 1, tag);
        end
        ev(0, 1, 0, 0, tag);
    endtask

    task automatic expect_level(input bit lvl, input string tag);
        total++;
        if (fault_status !== lvl) begin
            bad++;
            $display("FAIL %s: fault_status=%b expected=%b at %0t", tag, fault_status, lvl, $time);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_por = 1; m_sfe = 0; m_lfe = 0; m_ot = 0; m_in = 0; m_over = 0; m_fall = 0; m_rise = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R3 reset");
        expect_level(1'b1, "R3 reset level");
        @(negedge clk) rst_n = 1'b1;

        // R3: frame start releases power-up marker; R10: exact 8 clocks clean
        ev(1, 0, 0, 0, "R3");
        expect_level(1'b0, "R3 released");
        for (int i = 0; i < 8; i++) begin
            ev(0, 0, 1, 0, "R10");
            ev(0, 0, 0, 1, "R10");
        end
        ev(0, 1, 0, 0, "R10");
        expect_level(1'b0, "R10 exact frame");

        // R4 short frame, R5 released at 8th fall of next frame
        frame(5, "R4");
        expect_level(1'b1, "R4 latched");
        ev(1, 0, 0, 0, "R5");
        for (int i = 1; i <= 8; i++) begin
            ev(0, 0, 1, 0, "R5");
            expect_level(i < 8, "R5 release point");
            ev(0, 0, 0, 1, "R5");
        end
        ev(0, 1, 0, 0, "R5");

        // R6 overlong, R7 released at 2nd fall
        ev(1, 0, 0, 0, "R6");
        for (int i = 1; i <= 10; i++) begin
            ev(0, 0, 1, 0, "R6");
            ev(0, 0, 0, 1, "R6");
            expect_level(i >= 9, "R6 ninth rise");
        end
        ev(0, 1, 0, 0, "R6");
        ev(1, 0, 0, 0, "R7");
        ev(0, 0, 1, 0, "R7"); expect_level(1'b1, "R7 before");
        ev(0, 0, 0, 1, "R7");
        ev(0, 0, 1, 0, "R7"); expect_level(1'b0, "R7 at second fall");
        for (int i = 0; i < 6; i++) begin ev(0, 0, 0, 1, "R7"); ev(0, 0, 1, 0, "R7"); end
        ev(0, 0, 0, 1, "R7");
        ev(0, 1, 0, 0, "R7");

        // R8 overtemperature
        env('0, 1, 0, "R8"); expect_level(1'b1, "R8 set");
        frame(8, "R8");
        expect_level(1'b1, "R8 held while hot");
        env('0, 0, 0, "R8"); expect_level(1'b1, "R8 sticky");
        ev(1, 0, 0, 0, "R8");
        for (int i = 1; i <= 4; i++) begin
            ev(0, 0, 1, 0, "R8");
            expect_level(i < 4, "R8 fourth fall");
            ev(0, 0, 0, 1, "R8");
        end
        for (int i = 0; i < 4; i++) begin ev(0, 0, 1, 0, "R8"); ev(0, 0, 0, 1, "R8"); end
        ev(0, 1, 0, 0, "R8");

        // R1 live shorts
        env(8'h04, 0, 0, "R1"); expect_level(1'b1, "R1 short");
        env(8'h00, 0, 0, "R1"); expect_level(1'b0, "R1 gone");
        // R2 standby
        env(8'h00, 0, 1, "R2"); expect_level(1'b1, "R2 standby");
        env(8'h00, 0, 0, "R2"); expect_level(1'b0, "R2 active");

        // R9 clocks outside a frame
        frame(3, "R9");
        for (int i = 0; i < 8; i++) begin ev(0, 0, 1, 0, "R9"); ev(0, 0, 0, 1, "R9"); end
        expect_level(1'b1, "R9 idle clocks ignored");
        frame(8, "R9");
        expect_level(1'b0, "R9 cleared in frame");

        // R11 random mix
        for (int n = 0; n < 3000; n++) begin
            int a;
            a = int'($urandom_range(0, 9));
            if (a == 0) begin
                if (m_in) ev(0, 1, 0, 0, "R11"); else ev(1, 0, 0, 0, "R11");
            end else if (a <= 4) ev(0, 0, 1, 0, "R11");
            else if (a <= 7) ev(0, 0, 0, 1, "R11");
            else env(($urandom_range(0, 7) == 0) ? NCH'(1) << $urandom_range(0, NCH-1) : '0,
                     $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0, "R11");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule